// File: doc/BRIEF.md
# Data-Link Receive Mode Controller (HDLC / Bit-Oriented Message)

This block sits behind the framer that pulls the data-link bits out of a T1 extended superframe. It watches that sparse serial stream one valid bit at a time and decides whether the link currently carries HDLC frames or repeating bit-oriented messages. A long run of ones moves it from HDLC reception to message reception. A flag moves it back, and from that point it is ready for a frame at once.

In message mode an octet of eight ones gives byte alignment, and the eight bits after it form a candidate byte. The first received bit of the candidate lands in the LSB. The candidate goes to a receive FIFO through a one-cycle write strobe only when it is framed by zeros at both ends. A watchdog raises a pulse when alignment is not seen for 32 bits, and byte sampling continues. In HDLC mode the block only detects flags; deframing is done downstream.

Top module: `dl_rx_mode_ctrl`

## Requirements
- R1: After the asynchronous reset, or on the clock edge where `soft_rst_i` is high, `mode_bom_o` is 0 (HDLC), `bom_byte_o` is 0, all pulses are 0, the ones-run count is cleared and the flag history is refilled with ones.
- R2: Automatic switching into message mode happens only while both `hdlc_en_i` and `bom_en_i` are 1. While `bom_en_i` is 0, `mode_bom_o` is 0 from the next cycle on, whatever the stream carries.
- R3: In HDLC mode, with both enables set, the eighth consecutive valid 1 sets `mode_bom_o` on the following cycle. A run of seven ones followed by a 0 does not change the mode.
- R4: `flag_o` pulses for one cycle after each valid bit that completes the sequence 0,1,1,1,1,1,1,0 (in reception order) while `hdlc_en_i` is 1. In message mode such a flag clears `mode_bom_o` on the same edge.
- R5: In message mode, a run reaching exactly eight ones, including the run that caused entry, gives alignment when no candidate is being collected. The next eight valid bits form the candidate byte. Ones beyond the eighth belong to the candidate.
- R6: The candidate is assembled LSB first: the first bit after alignment is `bom_byte_o[0]` and the eighth is `bom_byte_o[7]`.
- R7: `bom_wr_o` pulses for one cycle, with the new `bom_byte_o`, only when candidate bits 0 and 7 are both 0. Any other candidate is dropped, and `bom_byte_o` keeps its last written value.
- R8: In message mode, when 32 valid bits pass without a run reaching eight ones, `sync_loss_o` pulses for one cycle and the 32-bit window restarts. Candidate collection is not interrupted. The window also restarts on entry to message mode.
- R9: Every counter and history advances only on cycles with `bit_valid_i` high. Idle cycles produce no pulse and no mode change.
- R10: On the return to HDLC mode, a partly collected candidate is dropped and the watchdog halts. No `bom_wr_o` or `sync_loss_o` occurs until message mode is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous reset, active high |
| hdlc_en_i | input | 1 | HDLC receiver enable (flag detection) |
| bom_en_i | input | 1 | Bit-oriented message receiver enable |
| bit_i | input | 1 | Serial data-link bit |
| bit_valid_i | input | 1 | Qualifies `bit_i` for this cycle |
| mode_bom_o | output | 1 | 1 = message mode, 0 = HDLC mode |
| bom_byte_o | output | 8 | Last accepted message byte, first bit in LSB |
| bom_wr_o | output | 1 | One-cycle write strobe toward the receive FIFO |
| flag_o | output | 1 | One-cycle flag-detected pulse |
| sync_loss_o | output | 1 | One-cycle loss-of-alignment interrupt pulse |

## Verification
Every result is registered once. The mode, the write strobe with its byte, the flag pulse and the sync-loss pulse therefore all appear on the first rising edge after the valid bit that causes them, and never later. The bench drives each bit on a falling edge and samples all outputs at the next falling edge. It then checks every idle cycle that follows for silent pulse outputs and an unchanged mode. Enable changes are checked one cycle after they are applied.

// File: rtl/dl_rx_pkg.sv
package dl_rx_pkg;
  typedef enum logic {MODE_HDLC = 1'b0, MODE_BOM = 1'b1} dl_mode_e;

  localparam int unsigned RUN_LEN_DEF = 8;
  localparam int unsigned BYTE_W_DEF  = 8;
  localparam int unsigned WD_LEN_DEF  = 32;
  localparam logic [7:0]  FLAG_DEF    = 8'b0111_1110;
endpackage

// File: rtl/dl_run_det.sv
// Ones-run counter and flag history over valid bits only.
module dl_run_det #(
  parameter int unsigned RUN_LEN = 8,
  parameter int unsigned FLAG_W  = 8,
  parameter logic [FLAG_W-1:0] FLAG_PAT = 8'b0111_1110
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic run_hit_o,
  output logic flag_hit_o
);
  localparam int unsigned RW = $clog2(RUN_LEN + 1);
  localparam logic [RW-1:0] RUN_MAX = RW'(RUN_LEN);
  localparam logic [RW-1:0] RUN_PRE = RW'(RUN_LEN - 1);

  logic [RW-1:0]     run_q;
  logic [FLAG_W-1:0] hist_q;
  logic [FLAG_W-1:0] hist_nx;

  assign hist_nx    = {hist_q[FLAG_W-2:0], bit_i};
  assign run_hit_o  = vld_i & bit_i & (run_q == RUN_PRE);
  assign flag_hit_o = vld_i & (hist_nx == FLAG_PAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      hist_q <= '1;
    end else if (srst_i) begin
      run_q  <= '0;
      hist_q <= '1;
    end else if (vld_i) begin
      hist_q <= hist_nx;
      if (!bit_i)                run_q <= '0;
      else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/dl_bom_cap.sv
// Candidate byte capture and alignment watchdog for message mode.
module dl_bom_cap #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned WD_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_i,
  input  logic              stop_i,
  input  logic              start_i,
  input  logic              bom_i,
  input  logic              vld_i,
  input  logic              bit_i,
  input  logic              run_hit_i,
  output logic              capping_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              wr_o,
  output logic              loss_o
);
  localparam int unsigned CW = $clog2(BYTE_W);
  localparam int unsigned WW = $clog2(WD_LEN);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);
  localparam logic [WW-1:0] WD_LAST  = WW'(WD_LEN - 1);

  logic              cap_q;
  logic [CW-1:0]     cnt_q;
  logic [BYTE_W-1:0] sh_q, byte_q, sh_nx;
  logic [WW-1:0]     wd_q;
  logic              wr_q, loss_q;

  assign sh_nx     = {bit_i, sh_q[BYTE_W-1:1]};
  assign capping_o = cap_q;
  assign byte_o    = byte_q;
  assign wr_o      = wr_q;
  assign loss_o    = loss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= 1'b0; cnt_q <= '0; sh_q <= '0; byte_q <= '0;
      wd_q  <= '0;   wr_q  <= 1'b0; loss_q <= 1'b0;
    end else begin
      wr_q   <= 1'b0;
      loss_q <= 1'b0;
      if (srst_i) begin
        cap_q <= 1'b0; cnt_q <= '0; byte_q <= '0; wd_q <= '0;
      end else if (stop_i) begin
        cap_q <= 1'b0; cnt_q <= '0; wd_q <= '0;
      end else if (start_i) begin
        cap_q <= 1'b1; cnt_q <= '0; wd_q <= '0;
      end else if (bom_i && vld_i) begin
        if (cap_q) begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            cap_q <= 1'b0;
            // keep only bytes framed by zeros
            if (!sh_nx[0] && !sh_nx[BYTE_W-1]) begin
              byte_q <= sh_nx;
              wr_q   <= 1'b1;
            end
          end
        end
        if (run_hit_i)            wd_q <= '0;
        else if (wd_q == WD_LAST) begin
          wd_q   <= '0;
          loss_q <= 1'b1;
        end else                  wd_q <= wd_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dl_rx_mode_ctrl.sv
module dl_rx_mode_ctrl
  import dl_rx_pkg::*;
#(
  parameter int unsigned RUN_LEN = RUN_LEN_DEF,
  parameter int unsigned BYTE_W  = BYTE_W_DEF,
  parameter int unsigned WD_LEN  = WD_LEN_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              hdlc_en_i,
  input  logic              bom_en_i,
  input  logic              bit_i,
  input  logic              bit_valid_i,
  output logic              mode_bom_o,
  output logic [BYTE_W-1:0] bom_byte_o,
  output logic              bom_wr_o,
  output logic              flag_o,
  output logic              sync_loss_o
);
  dl_mode_e mode_q;
  logic     flag_q;
  logic     run_hit, flag_hit, capping;
  logic     auto_en, in_bom, enter_bom, exit_flag, stop, start;

  assign auto_en   = hdlc_en_i & bom_en_i;
  assign in_bom    = (mode_q == MODE_BOM);
  assign enter_bom = ~in_bom & auto_en & run_hit;
  assign exit_flag = in_bom & hdlc_en_i & flag_hit;
  assign stop      = ~bom_en_i | exit_flag;
  assign start     = enter_bom | (in_bom & run_hit & ~capping);

  dl_run_det #(
    .RUN_LEN (RUN_LEN),
    .FLAG_W  (8),
    .FLAG_PAT(FLAG_DEF)
  ) u_run (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_i    (soft_rst_i),
    .vld_i     (bit_valid_i),
    .bit_i     (bit_i),
    .run_hit_o (run_hit),
    .flag_hit_o(flag_hit)
  );

  dl_bom_cap #(
    .BYTE_W(BYTE_W),
    .WD_LEN(WD_LEN)
  ) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_i   (soft_rst_i),
    .stop_i   (stop),
    .start_i  (start),
    .bom_i    (in_bom),
    .vld_i    (bit_valid_i),
    .bit_i    (bit_i),
    .run_hit_i(run_hit),
    .capping_o(capping),
    .byte_o   (bom_byte_o),
    .wr_o     (bom_wr_o),
    .loss_o   (sync_loss_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_HDLC;
      flag_q <= 1'b0;
    end else if (soft_rst_i) begin
      mode_q <= MODE_HDLC;
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_hit & hdlc_en_i;
      if (!bom_en_i)      mode_q <= MODE_HDLC;
      else if (enter_bom) mode_q <= MODE_BOM;
      else if (exit_flag) mode_q <= MODE_HDLC;
    end
  end

  assign mode_bom_o = in_bom;
  assign flag_o     = flag_q;
endmodule

// File: rtl/dl_rx_mode_ctrl_sva.sv
module dl_rx_mode_ctrl_sva #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              hdlc_en_i,
  input logic              bom_en_i,
  input logic              bit_i,
  input logic              bit_valid_i,
  input logic              mode_bom_o,
  input logic [BYTE_W-1:0] bom_byte_o,
  input logic              bom_wr_o,
  input logic              flag_o,
  input logic              sync_loss_o
);
  p_soft_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!mode_bom_o && !bom_wr_o && !flag_o && !sync_loss_o && bom_byte_o == '0));

  p_bom_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bom_en_i |=> !mode_bom_o);

  p_enter_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_bom_o) |-> $past(bit_valid_i && bit_i && hdlc_en_i && bom_en_i && !soft_rst_i));

  p_exit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_bom_o) |-> (flag_o || $past(soft_rst_i || !bom_en_i)));

  p_flag_hdlc_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o |-> (!mode_bom_o && $past(hdlc_en_i)));

  p_wr_framed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bom_wr_o |-> (!bom_byte_o[0] && !bom_byte_o[BYTE_W-1] && $past(mode_bom_o)));

  p_byte_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bom_wr_o && !$past(soft_rst_i)) |-> $stable(bom_byte_o));

  p_loss_bom_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_loss_o |-> $past(mode_bom_o));

  p_valid_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bom_wr_o || flag_o || sync_loss_o) |-> $past(bit_valid_i));

  p_quiet_hdlc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bom_wr_o || sync_loss_o) |-> $past(mode_bom_o));
endmodule

bind dl_rx_mode_ctrl dl_rx_mode_ctrl_sva #(.BYTE_W(BYTE_W)) u_sva (.*);

// File: tb/dl_rx_mode_ctrl_tb.sv
module dl_rx_mode_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0, hdlc_en = 1'b0, bom_en = 1'b0, dbit = 1'b0, vld = 1'b0;
  logic mode_bom, bom_wr, flag, sync_loss;
  logic [7:0] bom_byte;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  bit m_mode, m_capping;
  int m_run, m_capn, m_wd;
  logic [7:0] m_hist, m_cap, m_byte;
  bit e_wr, e_flag, e_loss;

  always #2.5 clk = ~clk;

  dl_rx_mode_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .hdlc_en_i(hdlc_en),
    .bom_en_i(bom_en), .bit_i(dbit), .bit_valid_i(vld), .mode_bom_o(mode_bom),
    .bom_byte_o(bom_byte), .bom_wr_o(bom_wr), .flag_o(flag), .sync_loss_o(sync_loss)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic m_clear();
    m_mode = 0; m_capping = 0; m_run = 0; m_capn = 0; m_wd = 0;
    m_hist = 8'hFF; m_cap = 8'h00; m_byte = 8'h00;
  endtask

  // model of one valid bit, from the requirements
  task automatic m_bit(input bit b);
    bit hit, flg;
    logic [7:0] nh;
    hit = b && (m_run == 7);
    nh  = {m_hist[6:0], b};
    flg = (nh == 8'h7E) && hdlc_en;
    e_wr = 0; e_loss = 0; e_flag = flg;
    if (!m_mode) begin
      if (hdlc_en && bom_en && hit) begin
        m_mode = 1; m_capping = 1; m_capn = 0; m_wd = 0;
      end
    end else if (flg) begin
      m_mode = 0; m_capping = 0; m_wd = 0;
    end else if (hit && !m_capping) begin
      m_capping = 1; m_capn = 0; m_wd = 0;
    end else begin
      if (m_capping) begin
        m_cap = {b, m_cap[7:1]};
        m_capn++;
        if (m_capn == 8) begin
          m_capping = 0;
          if (!m_cap[0] && !m_cap[7]) begin m_byte = m_cap; e_wr = 1; end
        end
      end
      if (hit) m_wd = 0;
      else if (m_wd == 31) begin e_loss = 1; m_wd = 0; end
      else m_wd++;
    end
    m_run  = b ? ((m_run < 8) ? m_run + 1 : 8) : 0;
    m_hist = nh;
  endtask

  task automatic idle_chk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9", "idle pulses", {bom_wr, flag, sync_loss}, 0);
      chk("R9", "idle mode", mode_bom, m_mode);
    end
  endtask

  task automatic send(input bit b, input int gap);
    dbit = b; vld = 1'b1;
    m_bit(b);
    @(negedge clk);
    vld = 1'b0;
    chk("R3/R4", "mode", mode_bom, m_mode);
    chk("R4", "flag", flag, e_flag);
    chk("R7", "write", bom_wr, e_wr);
    chk("R8", "sync loss", sync_loss, e_loss);
    chk("R6", "byte", bom_byte, m_byte);
    idle_chk(gap);
  endtask

  task automatic send_ones(input int n);
    for (int i = 0; i < n; i++) send(1'b1, 0);
  endtask

  task automatic send_byte(input logic [7:0] v, input int gap);
    for (int i = 0; i < 8; i++) send(v[i], gap);
  endtask

  task automatic set_en(input bit h, input bit m);
    hdlc_en = h; bom_en = m;
    if (!m) begin m_mode = 0; m_capping = 0; m_wd = 0; end
    idle_chk(1);
  endtask

  task automatic do_soft_rst();
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    m_clear();
    chk("R1", "soft reset mode", mode_bom, 0);
    chk("R1", "soft reset byte", bom_byte, 0);
    chk("R1", "soft reset pulses", {bom_wr, flag, sync_loss}, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5EED_0D1));
    m_clear();
    repeat (3) @(negedge clk);
    chk("R1", "reset mode", mode_bom, 0);
    chk("R1", "reset byte", bom_byte, 0);
    chk("R1", "reset pulses", {bom_wr, flag, sync_loss}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: HDLC only, long ones run keeps HDLC mode
    set_en(1, 0);
    send_ones(20);
    chk("R2", "hdlc-only mode", mode_bom, 0);
    send_byte(8'h7E, 1); // R4 flag in HDLC mode

    // R3: seven ones do not switch, eight do
    set_en(1, 1);
    send_ones(7); send(1'b0, 2);
    chk("R3", "seven ones", mode_bom, 0);
    send_ones(8);
    chk("R3", "eight ones", mode_bom, 1);

    // R5/R6/R7: framed byte written LSB first
    send_byte(8'b0101_1010, 1);
    chk("R6", "byte lsb first", bom_byte, 8'h5A);
    // R7: nine ones -> candidate starts with 1, dropped
    send_ones(9); send_byte(8'b0010_1100, 0);
    chk("R7", "start-one kept old", bom_byte, 8'h5A);
    // R7: candidate ending in 1 dropped
    send_ones(8); send_byte(8'b1001_0100, 0);
    chk("R7", "end-one kept old", bom_byte, 8'h5A);

    // R8: 70 zeros in BOM mode -> periodic loss, capture continues
    for (int i = 0; i < 70; i++) send(1'b0, 0);
    chk("R8", "still bom", mode_bom, 1);

    // R4/R10: flag as candidate exits, no write, watchdog halts
    send_ones(8); send_byte(8'h7E, 0);
    chk("R4", "flag exit", mode_bom, 0);
    for (int i = 0; i < 40; i++) send(1'b0, 0);

    // R2: drop bom enable while in message mode
    send_ones(8);
    set_en(1, 0);
    chk("R2", "bom disable", mode_bom, 0);
    set_en(1, 1);

    // R1: soft reset while in message mode
    send_ones(8);
    do_soft_rst();

    // random repeating messages with gaps
    for (int k = 0; k < 150; k++) begin
      int pre, gap;
      logic [5:0] p;
      pre = ($urandom % 5 == 0) ? 9 : 8;
      p = 6'($urandom);
      if (p == 6'h3F) p = 6'h15;
      gap = $urandom % 3;
      for (int i = 0; i < pre; i++) send(1'b1, gap);
      v = {1'b0, p, 1'b0};
      if ($urandom % 6 == 0) v[7] = 1'b1;
      send_byte(v, gap);
      if ($urandom % 25 == 0) send_byte(8'h7E, 0);
    end

    // biased random stream with enable changes
    for (int i = 0; i < 4000; i++) begin
      if (i % 700 == 350) set_en(1'($urandom), 1'($urandom % 4 != 0));
      if (i % 1000 == 999) do_soft_rst();
      send(1'($urandom % 4 != 0), $urandom % 2);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule